// File: doc/BRIEF.md
# Serial Delay-Setting Register

This block is the digital programming port of an 8-bit programmable timing element. A host shifts a delay code into an input shift register over a three-wire serial link: data in, serial clock and latch enable. The register's top bit always drives the serial output. When latch enable is released, the register contents become the active delay code. A one-cycle settle request is raised only if that code differs from the code that was active before.

All port inputs are sampled on a system clock, and the serial clock and latch enable edges are found from those samples. Several blocks form a daisy chain by wiring each serial output to the next block's serial input. A read is destructive, because shifting pushes the contents out. Feeding the last serial output back to the first serial input restores the contents after eight serial clocks per block. A read done this way leaves the active code unchanged and raises no settle request.

Top module: `serial_delay_reg`

## Requirements
- R1: While rst_ni is low, the input register and code_o are all zero, sdo_o is 0 and settle_o is 0.
- R2: sdo_o shows bit 7 (the MSB) of the input register. After each accepted shift, sdo_o carries the value that was in bit 6 before the shift.
- R3: A shift is accepted on a sampled rising serial clock (sclk_i high now, low in the previous sample) when le_i is high in both the current and the previous sample. The register then becomes {reg[6:0], sdi_i}, so the MSB leaves first and the new bit enters at bit 0.
- R4: A serial clock rise is ignored while le_i is low, and also in the sample where le_i first goes high. The input register is unchanged in both cases.
- R5: On a sampled falling le_i (high in the previous sample, low now), code_o loads the input register on that clock edge.
- R6: code_o holds its value on every clock edge that is not a commit.
- R7: settle_o is high for exactly the one cycle in which a commit updates code_o, and only if the new code differs from the previous code.
- R8: With the last serial output looped back to the first serial input, eight accepted shifts per block restore every register, and the following commit leaves code_o unchanged with settle_o low.
- R9: In a chain, the first bits shifted in end up in the block farthest from the input. Sixteen shifts load two chained blocks, the far block's code MSB first and then the near block's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; a sampled rise shifts the register |
| le_i | input | 1 | Latch enable; high opens access, a fall commits the code |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output, the register MSB |
| code_o | output | CODE_W | Active delay code |
| settle_o | output | 1 | One-cycle pulse when the committed code changes |

## Verification
The hardest condition to reach is a non-destructive readback. It needs a full sixteen-shift circulation through two chained blocks with the far output fed back to the near input, followed by a commit that must produce no settle pulse. The bench reaches it by switching the near block's serial input onto the far block's output for a whole read pass, and it checks every bit that appears on the far output along the way. Ignored serial clocks are brought out the same way: a loopback read after the ignored pulses must show the old contents.

// File: rtl/serial_delay_pkg.sv
package serial_delay_pkg;
  typedef struct packed {
    logic sclk_rise;
    logic le_rise;
    logic le_fall;
    logic le_held;
  } port_ev_t;
endpackage

// File: rtl/sdr_edge_det.sv
module sdr_edge_det
  import serial_delay_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_i,
  input  logic     le_i,
  output port_ev_t ev_o
);
  logic sclk_q, le_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      le_q   <= le_i;
    end
  end

  always_comb begin
    ev_o.sclk_rise = sclk_i & ~sclk_q;
    ev_o.le_rise   = le_i & ~le_q;
    ev_o.le_fall   = le_q & ~le_i;
    ev_o.le_held   = le_i & le_q;
  end
endmodule

// File: rtl/sdr_shift_reg.sv
module sdr_shift_reg
  import serial_delay_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  port_ev_t     ev_i,
  input  logic         sdi_i,
  output logic [W-1:0] data_o,
  output logic         msb_o
);
  logic shift_en;
  logic [W-1:0] data_q;

  // a rise in the same sample as the le rise does not count
  assign shift_en = ev_i.le_held & ev_i.sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (shift_en) data_q <= {data_q[W-2:0], sdi_i};
  end

  assign data_o = data_q;
  assign msb_o  = data_q[W-1];
endmodule

// File: rtl/sdr_commit.sv
module sdr_commit
  import serial_delay_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  port_ev_t     ev_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] code_o,
  output logic         settle_o
);
  logic [W-1:0] code_q;
  logic settle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      settle_q <= 1'b0;
    end else if (ev_i.le_fall) begin
      code_q   <= data_i;
      settle_q <= (data_i != code_q);
    end else begin
      settle_q <= 1'b0;
    end
  end

  assign code_o   = code_q;
  assign settle_o = settle_q;
endmodule

// File: rtl/serial_delay_reg.sv
module serial_delay_reg
  import serial_delay_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              le_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [CODE_W-1:0] code_o,
  output logic              settle_o
);
  port_ev_t ev;
  logic [CODE_W-1:0] shift_q;

  sdr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .le_i   (le_i),
    .ev_o   (ev)
  );

  sdr_shift_reg #(.W(CODE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .sdi_i  (sdi_i),
    .data_o (shift_q),
    .msb_o  (sdo_o)
  );

  sdr_commit #(.W(CODE_W)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .data_i   (shift_q),
    .code_o   (code_o),
    .settle_o (settle_o)
  );
endmodule

// File: rtl/serial_delay_reg_chk.sv
module serial_delay_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sclk_i,
  input logic         le_i,
  input logic         sdi_i,
  input logic         sdo_o,
  input logic [W-1:0] code_o,
  input logic         settle_o,
  input logic [W-1:0] shift_q
);
  logic prev_le, prev_sclk, live;
  logic sh, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_le   <= 1'b0;
      prev_sclk <= 1'b0;
      live      <= 1'b0;
    end else begin
      prev_le   <= le_i;
      prev_sclk <= sclk_i;
      live      <= 1'b1;
    end
  end

  assign sh   = le_i && prev_le && sclk_i && !prev_sclk;
  assign fall = prev_le && !le_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_zero: assert (code_o == '0 && shift_q == '0 && !sdo_o && !settle_o);
    end
  end

  a_r2_msb_next: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    sh |=> sdo_o == $past(shift_q[W-2]));
  a_r3_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    sh |=> shift_q == {$past(shift_q[W-2:0]), $past(sdi_i)});
  a_r4_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    !sh |=> $stable(shift_q));
  a_r5_commit: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    fall |=> code_o == $past(shift_q));
  a_r6_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    !fall |=> $stable(code_o));
  a_r7_settle_change: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    fall |=> settle_o == (code_o != $past(code_o)));
  a_r7_settle_only: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    !fall |=> !settle_o);
endmodule

bind serial_delay_reg serial_delay_reg_chk #(.W(CODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_i   (sclk_i),
  .le_i     (le_i),
  .sdi_i    (sdi_i),
  .sdo_o    (sdo_o),
  .code_o   (code_o),
  .settle_o (settle_o),
  .shift_q  (shift_q)
);

// File: tb/sim_serial_delay_reg.sv
module sim_serial_delay_reg;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] c0;
    logic [W-1:0] c1;
    logic s0;
    logic s1;
    string req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, le = 1'b0, sdi_drv = 1'b0, loop = 1'b0;
  logic sdo0, sdo1, set0, set1, sdi0;
  logic [W-1:0] code0, code1;

  logic [W-1:0] m0 = '0, m1 = '0, k0 = '0, k1 = '0;
  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sdi0 = loop ? sdo1 : sdi_drv;

  serial_delay_reg #(.CODE_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .le_i(le), .sdi_i(sdi0),
    .sdo_o(sdo0), .code_o(code0), .settle_o(set0));
  serial_delay_reg #(.CODE_W(W)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .le_i(le), .sdi_i(sdo0),
    .sdo_o(sdo1), .code_o(code1), .settle_o(set1));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one accepted serial clock; model updates, far output checked
  task automatic pulse(input logic b, input string req);
    logic din;
    din = loop ? m1[W-1] : b;
    sdi_drv = b;
    sclk = 1'b1;
    @(negedge clk);
    m1 = {m1[W-2:0], m0[W-1]};
    m0 = {m0[W-2:0], din};
    sclk = 1'b0;
    check(sdo1 === m1[W-1], req, sdo1, m1[W-1]);
    check(sdo0 === m0[W-1], "R2", sdo0, m0[W-1]);
    @(negedge clk);
  endtask

  task automatic open_le();
    le = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic close_le(input string req);
    exp_t e;
    e.c0 = m0; e.c1 = m1;
    e.s0 = (m0 != k0); e.s1 = (m1 != k1);
    e.req = req;
    k0 = m0; k1 = m1;
    q.push_back(e);
    le = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // R9: far code first, MSB first
  task automatic write2(input logic [W-1:0] far, input logic [W-1:0] near, input string req);
    open_le();
    for (int i = W - 1; i >= 0; i--) pulse(far[i], "R9");
    for (int i = W - 1; i >= 0; i--) pulse(near[i], "R9");
    close_le(req);
  endtask

  task automatic read_back(input string req);
    open_le();
    loop = 1'b1;
    for (int i = 0; i < 2 * W; i++) pulse(1'b0, req);
    loop = 1'b0;
    close_le(req);
  endtask

  // monitor: scoreboard pop on each commit
  initial begin
    forever begin
      @(negedge le);
      @(posedge clk);
      @(negedge clk);
      if (q.size() == 0) begin
        check(1'b0, "R5", 0, 1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(code0 === e.c0, {e.req, " R5 near"}, code0, e.c0);
        check(code1 === e.c1, {e.req, " R5 far"}, code1, e.c1);
        check(set0 === e.s0, {e.req, " R7 near"}, set0, e.s0);
        check(set1 === e.s1, {e.req, " R7 far"}, set1, e.s1);
        @(negedge clk);
        check(!set0 && !set1, "R7 one cycle", {set0, set1}, 0);
        check(code0 === e.c0, "R6 hold", code0, e.c0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(code0 === '0 && code1 === '0, "R1 code", {code1, code0}, 0);
    check(!sdo0 && !sdo1 && !set0 && !set1, "R1 outputs", {sdo0, sdo1, set0, set1}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    write2(8'h3C, 8'hA5, "R3 R9 first write");
    read_back("R8 loopback");
    write2(8'h3C, 8'hA5, "R7 same code");
    write2(8'h3C, 8'h5A, "R7 near only");
    write2(8'hFF, 8'h00, "R3 extremes");
    read_back("R8 extremes");

    // R4: clocks with le low are ignored
    sdi_drv = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; @(negedge clk);
      sclk = 1'b0; @(negedge clk);
    end
    check(code0 === k0 && code1 === k1, "R4 R6 code", {code1, code0}, {k1, k0});
    check(sdo1 === m1[W-1], "R4 sdo", sdo1, m1[W-1]);
    // R4: rise in the same sample as le rise is ignored
    le = 1'b1; sclk = 1'b1;
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
    check(sdo1 === m1[W-1] && sdo0 === m0[W-1], "R4 le-rise clock", {sdo1, sdo0}, {m1[W-1], m0[W-1]});
    loop = 1'b1;
    for (int i = 0; i < 2 * W; i++) pulse(1'b0, "R4 readout");
    loop = 1'b0;
    close_le("R4 R8 unchanged");

    write2(8'h81, 8'h7E, "R3 R9 final");
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R5 scoreboard drained", q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule